// File: doc/BRIEF.md
# Framebuffer DMA Line Fetcher

This block is the memory-side front end of a display pipeline. It masters a simple request/grant read port, walks the frame buffer one burst of 32-bit words at a time, and pushes the returned words into a local pixel FIFO. The display timing logic drains the FIFO. Fetching is paced by FIFO occupancy: a new burst is only asked for when the FIFO has room to spare. The room margin covers the new burst, one more burst and a small allowance.

The frame is read as a two-dimensional window. Each visible line is a run of consecutive words. After the last word of a line, the address jumps forward by a skip distance in bytes, which steps over the part of a wider virtual screen that is not shown. After the programmed number of words, the address returns to the base for the next frame. A sub-word pixel offset travels alongside the frame for the pixel unpacker.

All configuration inputs act as shadow values. They reach the active set only after an update strobe, and only at the next frame start. A busy flag stays high while the engine is enabled, or while a burst that was already started is still completing after the engine is disabled. Software waits for it to fall before reprogramming.

Top module: `fb_line_fetch`

## Requirements
- R1: After reset, busy_o, rd_req_o and pix_valid_o are low and update_pending_o is high, so the first enabled frame loads the configuration inputs.
- R2: rd_addr_o always has its two low bits at zero. The two low bits of cfg_base_i are ignored.
- R3: Each request asks for min(burst, words left in the line, words left in the frame) words. rd_len_o carries that count minus one, and the burst is cfg_burst_m1_i + 1.
- R4: Words within a line are contiguous. The burst after the one that ends a line starts at the line-end address plus cfg_skip_bytes_i.
- R5: After cfg_frame_words_i words, the next request starts again at the base address.
- R6: A request is only raised when FIFO occupancy plus 2 × burst + 3 does not exceed DEPTH. With the consumer stalled, filling stops with occupancy above DEPTH − (2 × burst + 3) and at most burst words beyond that.
- R7: pix_data_o delivers words in fetch order. A push and a pop in the same cycle lose and duplicate nothing.
- R8: Changes on the configuration inputs are ignored until update_i is pulsed. The new set, including pix_off_o, takes effect at the next frame start. update_pending_o rises after the strobe and falls when the set is copied.
- R9: When enable_i falls during a burst, busy_o stays high until the last word of that burst arrives, then falls. No request follows. On re-enable, fetching restarts at the base address.
- R10: Once raised, rd_req_o, rd_addr_o and rd_len_o hold steady until rd_gnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the fetch engine |
| update_i | input | 1 | One-cycle strobe: commit the shadow configuration at the next frame start |
| cfg_base_i | input | AW | Frame base byte address (low two bits ignored) |
| cfg_frame_words_i | input | FW | Words per frame |
| cfg_line_words_i | input | LW | Words per visible line |
| cfg_skip_bytes_i | input | SW | Bytes skipped after each line |
| cfg_burst_m1_i | input | BW | Burst length in words minus one |
| cfg_pix_off_i | input | 5 | Pixel bit offset within the first word |
| rd_req_o | output | 1 | Read burst request |
| rd_addr_o | output | AW | Burst start byte address, word aligned |
| rd_len_o | output | BW | Burst words minus one |
| rd_gnt_i | input | 1 | Request accepted |
| rd_valid_i | input | 1 | Read data word valid |
| rd_data_i | input | DW | Read data word |
| pix_valid_o | output | 1 | FIFO holds a word |
| pix_data_o | output | DW | Head FIFO word |
| pix_pop_i | input | 1 | Consume the head word |
| pix_off_o | output | 5 | Active pixel offset |
| busy_o | output | 1 | Engine enabled or burst still completing |
| update_pending_o | output | 1 | Update strobe seen, not yet committed |

## Verification
Two pairs of functions can land on the same cycle. The FIFO can take a word from the read port while the consumer pops one. The frame wrap can also meet a burst that has been cut short because the frame ends. The bench keeps the consumer popping while return data arrives with and without gaps. It uses frame sizes that are not a multiple of the burst, so bursts are cut at both line and frame ends. An independent address model checks every request, and a scoreboard checks every popped word against it. A stalled-consumer phase then checks that the occupancy settles inside the threshold window.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_REQ  = 2'd2,
    ST_DATA = 2'd3
  } fetch_st_e;
endpackage

// File: rtl/fb_fetch_cfg.sv
module fb_fetch_cfg #(
  parameter int AW        = 32,
  parameter int FW        = 20,
  parameter int LW        = 12,
  parameter int SW        = 16,
  parameter int BW        = 4,
  parameter int DEF_BURST = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          update_i,
  input  logic          commit_i,
  input  logic [AW-1:0] sh_base_i,
  input  logic [FW-1:0] sh_frame_i,
  input  logic [LW-1:0] sh_line_i,
  input  logic [SW-1:0] sh_skip_i,
  input  logic [BW-1:0] sh_burst_m1_i,
  input  logic [4:0]    sh_off_i,
  output logic [AW-1:0] act_base_o,
  output logic [FW-1:0] act_frame_o,
  output logic [LW-1:0] act_line_o,
  output logic [SW-1:0] act_skip_o,
  output logic [BW-1:0] act_burst_m1_o,
  output logic [4:0]    act_off_o,
  output logic          pending_o
);
  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_base_o     <= '0;
      act_frame_o    <= '0;
      act_line_o     <= '0;
      act_skip_o     <= '0;
      act_burst_m1_o <= BW'(DEF_BURST - 1);
      act_off_o      <= '0;
    end else if (commit_i && pending_q) begin
      act_base_o     <= {sh_base_i[AW-1:2], 2'b00};
      act_frame_o    <= sh_frame_i;
      act_line_o     <= sh_line_i;
      act_skip_o     <= sh_skip_i;
      act_burst_m1_o <= sh_burst_m1_i;
      act_off_o      <= sh_off_i;
    end
  end

  // strobe wins over commit so a late update is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pending_q <= 1'b1;
    else if (update_i) pending_q <= 1'b1;
    else if (commit_i) pending_q <= 1'b0;
  end

  assign pending_o = pending_q;

  a_r8_pending_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q && commit_i && !update_i |=> !pending_q);

  a_r8_off_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && pending_q) |=> $stable(act_off_o) && $stable(act_base_o));
endmodule

// File: rtl/fb_pix_fifo.sv
module fb_pix_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 512,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign valid_o = cnt_q != '0;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(do_pop);
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CW'(DEPTH));
endmodule

// File: rtl/fb_fetch_ctrl.sv
module fb_fetch_ctrl
  import fb_fetch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int FW    = 20,
  parameter int LW    = 12,
  parameter int SW    = 16,
  parameter int BW    = 4,
  parameter int DEPTH = 512,
  parameter int CW    = 10,
  localparam int LENW = BW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [AW-1:0] act_base_i,
  input  logic [FW-1:0] act_frame_i,
  input  logic [LW-1:0] act_line_i,
  input  logic [SW-1:0] act_skip_i,
  input  logic [BW-1:0] act_burst_m1_i,
  input  logic [CW-1:0] fifo_count_i,
  input  logic          rd_gnt_i,
  input  logic          rd_valid_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [BW-1:0] rd_len_o,
  output logic          push_o,
  output logic          commit_o,
  output logic          busy_o
);
  fetch_st_e       st_q;
  logic [AW-1:0]   addr_q, addr_n;
  logic [LW-1:0]   line_q, line_n;
  logic [FW-1:0]   frame_q, frame_n;
  logic [LENW-1:0] len_q, beats_q, len_c;
  logic            start_q, room_ok;
  logic [31:0]     blen32, len32;

  always_comb begin
    blen32 = 32'(act_burst_m1_i) + 32'd1;
    len32  = blen32;
    if (32'(line_q) < len32)  len32 = 32'(line_q);
    if (32'(frame_q) < len32) len32 = 32'(frame_q);
    len_c   = LENW'(len32);
    room_ok = 32'(fifo_count_i) + (blen32 << 1) + 32'd3 <= 32'(DEPTH);
    addr_n  = addr_q + (AW'(len_q) << 2);
    line_n  = line_q - LW'(len_q);
    frame_n = frame_q - FW'(len_q);
  end

  assign rd_req_o  = st_q == ST_REQ;
  assign rd_addr_o = {addr_q[AW-1:2], 2'b00};
  assign rd_len_o  = BW'(len_q - 1'b1);
  assign push_o    = (st_q == ST_DATA) && rd_valid_i;
  assign commit_o  = (st_q == ST_IDLE) && enable_i && start_q;
  assign busy_o    = enable_i || (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      line_q  <= '0;
      frame_q <= '0;
      len_q   <= '0;
      beats_q <= '0;
      start_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (!enable_i)    start_q <= 1'b1;
          else if (start_q) st_q    <= ST_LOAD;
          else if (room_ok) begin
            len_q <= len_c;
            st_q  <= ST_REQ;
          end
        end
        ST_LOAD: begin
          addr_q  <= act_base_i;
          line_q  <= act_line_i;
          frame_q <= act_frame_i;
          start_q <= 1'b0;
          st_q    <= ST_IDLE;
        end
        ST_REQ: begin
          if (rd_gnt_i) begin
            beats_q <= len_q;
            st_q    <= ST_DATA;
            frame_q <= frame_n;
            if (frame_n == '0) begin
              start_q <= 1'b1;
            end else if (line_n == '0) begin
              addr_q <= addr_n + AW'(act_skip_i);
              line_q <= act_line_i;
            end else begin
              addr_q <= addr_n;
              line_q <= line_n;
            end
          end
        end
        ST_DATA: begin
          if (rd_valid_i) begin
            beats_q <= beats_q - 1'b1;
            if (beats_q == LENW'(1)) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_len_o));

  a_r6_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> 32'(fifo_count_i) + 32'(len_q) <= 32'(DEPTH));

  a_r3_len_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_len_o <= act_burst_m1_i);

  a_r2_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[1:0] == 2'b00);
endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch #(
  parameter int AW        = 32,
  parameter int FW        = 20,
  parameter int LW        = 12,
  parameter int SW        = 16,
  parameter int BW        = 4,
  parameter int DW        = 32,
  parameter int DEPTH     = 512,
  parameter int DEF_BURST = 8,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          update_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [FW-1:0] cfg_frame_words_i,
  input  logic [LW-1:0] cfg_line_words_i,
  input  logic [SW-1:0] cfg_skip_bytes_i,
  input  logic [BW-1:0] cfg_burst_m1_i,
  input  logic [4:0]    cfg_pix_off_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [BW-1:0] rd_len_o,
  input  logic          rd_gnt_i,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          pix_valid_o,
  output logic [DW-1:0] pix_data_o,
  input  logic          pix_pop_i,
  output logic [4:0]    pix_off_o,
  output logic          busy_o,
  output logic          update_pending_o
);
  logic [AW-1:0] act_base;
  logic [FW-1:0] act_frame;
  logic [LW-1:0] act_line;
  logic [SW-1:0] act_skip;
  logic [BW-1:0] act_burst_m1;
  logic [CW-1:0] fifo_count;
  logic          commit, push;

  fb_fetch_cfg #(
    .AW(AW), .FW(FW), .LW(LW), .SW(SW), .BW(BW), .DEF_BURST(DEF_BURST)
  ) u_cfg (
    .clk_i, .rst_ni, .update_i,
    .commit_i      (commit),
    .sh_base_i     (cfg_base_i),
    .sh_frame_i    (cfg_frame_words_i),
    .sh_line_i     (cfg_line_words_i),
    .sh_skip_i     (cfg_skip_bytes_i),
    .sh_burst_m1_i (cfg_burst_m1_i),
    .sh_off_i      (cfg_pix_off_i),
    .act_base_o    (act_base),
    .act_frame_o   (act_frame),
    .act_line_o    (act_line),
    .act_skip_o    (act_skip),
    .act_burst_m1_o(act_burst_m1),
    .act_off_o     (pix_off_o),
    .pending_o     (update_pending_o)
  );

  fb_fetch_ctrl #(
    .AW(AW), .FW(FW), .LW(LW), .SW(SW), .BW(BW), .DEPTH(DEPTH), .CW(CW)
  ) u_ctrl (
    .clk_i, .rst_ni, .enable_i,
    .act_base_i    (act_base),
    .act_frame_i   (act_frame),
    .act_line_i    (act_line),
    .act_skip_i    (act_skip),
    .act_burst_m1_i(act_burst_m1),
    .fifo_count_i  (fifo_count),
    .rd_gnt_i, .rd_valid_i, .rd_req_o, .rd_addr_o, .rd_len_o,
    .push_o        (push),
    .commit_o      (commit),
    .busy_o
  );

  fb_pix_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (rd_data_i),
    .pop_i  (pix_pop_i),
    .data_o (pix_data_o),
    .valid_o(pix_valid_o),
    .count_o(fifo_count)
  );
endmodule

// File: tb/fb_line_fetch_tb.sv
module fb_line_fetch_tb;
  localparam int AW = 32, FW = 20, LW = 12, SW = 16, BW = 4, DW = 32, DEPTH = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, update = 1'b0;
  logic [AW-1:0] sh_base = 32'h0000_1003;
  logic [FW-1:0] sh_frame = 20'd15;
  logic [LW-1:0] sh_line = 12'd5;
  logic [SW-1:0] sh_skip = 16'd8;
  logic [BW-1:0] sh_bm1 = 4'd3;
  logic [4:0]    sh_off = 5'd5;
  logic rd_req, rd_gnt = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [BW-1:0] rd_len;
  logic [DW-1:0] rd_data = '0, pix_data;
  logic pix_valid, pix_pop = 1'b0, busy, pending;
  logic [4:0] pix_off;

  always #5 clk = ~clk;

  fb_line_fetch #(.AW(AW), .FW(FW), .LW(LW), .SW(SW), .BW(BW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .update_i(update),
    .cfg_base_i(sh_base), .cfg_frame_words_i(sh_frame), .cfg_line_words_i(sh_line),
    .cfg_skip_bytes_i(sh_skip), .cfg_burst_m1_i(sh_bm1), .cfg_pix_off_i(sh_off),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_len_o(rd_len), .rd_gnt_i(rd_gnt),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .pix_valid_o(pix_valid),
    .pix_data_o(pix_data), .pix_pop_i(pix_pop), .pix_off_o(pix_off),
    .busy_o(busy), .update_pending_o(pending));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q [$];
  // bench model of the active configuration and walk position
  logic [AW-1:0] m_base, m_addr;
  int  m_frame_tot, m_line_tot, m_skip, m_burst, m_off;
  int  m_line, m_frame, m_frames = 0, m_reqs = 0;
  bit  m_at_start = 1'b1, b_pending = 1'b1;
  bit  pop_en = 1'b0, gap_mode = 1'b0, hold_mode = 1'b0, held = 1'b0;
  int  beats_left = 0, gap_cnt = 0;
  logic [AW-1:0] cur, held_addr;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bus, memory model, request checker and pixel scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (pop_en && pix_valid) begin
        pix_pop = 1'b1;
        if (exp_q.size() == 0) chk(1'b0, "R7 pop with empty scoreboard", pix_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(pix_data == e, "R7 pixel word order", pix_data, e);
        end
      end else pix_pop = 1'b0;

      rd_gnt = 1'b0;
      if (beats_left > 0) begin
        if (gap_mode && gap_cnt == 2) begin
          rd_valid = 1'b0;
          gap_cnt = 0;
        end else begin
          rd_valid = 1'b1;
          rd_data = cur;
          cur += 4;
          beats_left--;
          gap_cnt++;
        end
      end else begin
        rd_valid = 1'b0;
        if (rd_req && hold_mode && !held) begin
          held = 1'b1;
          held_addr = rd_addr;
        end else if (rd_req) begin
          int len;
          if (held) chk(rd_addr == held_addr, "R10 request held until grant", rd_addr, held_addr);
          held = 1'b0;
          if (m_at_start) begin
            if (b_pending) begin
              m_base = {sh_base[AW-1:2], 2'b00};
              m_frame_tot = int'(sh_frame);
              m_line_tot = int'(sh_line);
              m_skip = int'(sh_skip);
              m_burst = int'(sh_bm1) + 1;
              m_off = int'(sh_off);
              b_pending = 1'b0;
            end
            m_addr = m_base;
            m_line = m_line_tot;
            m_frame = m_frame_tot;
            m_at_start = 1'b0;
          end
          len = m_burst;
          if (m_line < len) len = m_line;
          if (m_frame < len) len = m_frame;
          chk(rd_addr == m_addr, "R2 R4 R5 burst address", rd_addr, m_addr);
          chk(int'(rd_len) == len - 1, "R3 burst length", rd_len, len - 1);
          chk(int'(pix_off) == m_off, "R8 active pixel offset", pix_off, m_off);
          for (int i = 0; i < len; i++) exp_q.push_back(m_addr + AW'(4 * i));
          cur = m_addr;
          beats_left = len;
          gap_cnt = 0;
          rd_gnt = 1'b1;
          m_reqs++;
          m_frame -= len;
          m_line -= len;
          if (m_frame == 0) begin
            m_at_start = 1'b1;
            m_frames++;
          end else if (m_line == 0) begin
            m_addr = m_addr + AW'(4 * len + m_skip);
            m_line = m_line_tot;
          end else m_addr = m_addr + AW'(4 * len);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(rd_req == 1'b0, "R1 no request after reset", rd_req, 0);
    chk(pix_valid == 1'b0, "R1 fifo empty after reset", pix_valid, 0);
    chk(pending == 1'b1, "R1 update pending after reset", pending, 1);
    rst_n = 1'b1;
    @(negedge clk);
    pop_en = 1'b1;
    enable = 1'b1;
    wait (m_frames >= 3);
    @(negedge clk);
    chk(pending == 1'b0, "R8 initial load committed", pending, 0);

    // R8: new values ignored until strobe
    hold_mode = 1'b1;
    sh_base = 32'h0000_2000; sh_frame = 20'd12; sh_line = 12'd6;
    sh_skip = 16'd4; sh_bm1 = 4'd1; sh_off = 5'd17;
    begin
      int r0;
      r0 = m_reqs;
      wait (m_reqs >= r0 + 4);
    end
    hold_mode = 1'b0;
    do @(negedge clk); while (m_at_start);
    update = 1'b1;
    b_pending = 1'b1;
    @(negedge clk);
    update = 1'b0;
    chk(pending == 1'b1, "R8 pending after strobe", pending, 1);
    begin
      int f0;
      f0 = m_frames;
      wait (m_frames >= f0 + 3);
    end
    @(negedge clk);
    chk(pending == 1'b0, "R8 pending cleared at frame start", pending, 0);
    chk(pix_off == 5'd17, "R8 new offset active", pix_off, 17);

    // R6: stall consumer, fill stops inside threshold window (burst 2 -> 25)
    pop_en = 1'b0;
    repeat (300) @(negedge clk);
    chk(rd_req == 1'b0, "R6 no request when fifo above threshold", rd_req, 0);
    chk(exp_q.size() > 25 && exp_q.size() <= 27, "R6 final occupancy", exp_q.size(), 26);
    chk(pix_valid == 1'b1, "R6 fifo holds data", pix_valid, 1);
    pop_en = 1'b1;
    gap_mode = 1'b1;
    begin
      int f0;
      f0 = m_frames;
      wait (m_frames >= f0 + 2);
    end
    gap_mode = 1'b0;

    // R9: disable mid burst
    do @(negedge clk); while (beats_left < 2);
    enable = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy during trailing burst", busy, 1);
    begin
      int guard = 0;
      while (busy && guard < 100) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(beats_left == 0, "R9 busy falls after last word", beats_left, 0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (rd_req) seen = 1'b1;
      end
      chk(!seen, "R9 no request while disabled", seen, 0);
    end
    m_at_start = 1'b1;
    enable = 1'b1;
    begin
      int f0;
      f0 = m_frames;
      wait (m_frames >= f0 + 2);
    end
    enable = 1'b0;
    repeat (200) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule